// File: doc/BRIEF.md
# Fuse Word Programming Sequencer

This block burns one 32-bit word into a bank of eight one-time-programmable fuse words. Software loads a word index into an address register and a value into a data register, then pulses a write request. If the word is not locked by the protection mask, the block copies the index into a private latch, raises BUSY and walks the serial fuse chain one bit position every `CLKS_PER_BIT` clocks. It first steps through the positions of all lower words without programming them, then shifts the data register right with zero fill. Each data bit equal to 1 produces a single-cycle program strobe toward the fuse array.

When the last bit is done, BUSY drops and a settling window of `POST_CYCLES` clocks follows (2 µs at the configured clock). POST_WAIT is high during this window, and any request made then is discarded and raises ERROR. A request to a locked word never reaches the array and never raises BUSY: it sets ERROR instead. ERROR is sticky. While it is set, requests are ignored until software pulses the clear input.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, and after any reset applied during a write, busy_o, post_wait_o, error_o, fuse_pgm_o and data_o are all 0.
- R2: An accepted request raises busy_o at the next clock edge. busy_o then stays high for exactly (n+1)·32·CLKS_PER_BIT cycles, where n is the latched word index (0..7).
- R3: During the data phase, fuse_idx_o equals n·32+k while data bit k is presented, with bits taken LSB first. data_o shifts right by one with a 0 entering bit 31 every CLKS_PER_BIT cycles, and it is 0 when the write ends.
- R4: fuse_pgm_o pulses for exactly one cycle for each data bit equal to 1, and never for a 0 bit. It stays low during the positioning slots of lower words.
- R5: Writing the address register while busy_o is high does not change the word being programmed.
- R6: Writing the data register while busy_o is high has no effect.
- R7: A request to word w while prot_mask_i[w] is 1 leaves busy_o low and produces no strobe. It sets error_o.
- R8: While error_o is 1, requests are ignored. A one-cycle err_clr_i pulse returns error_o to 0.
- R9: After busy_o falls, post_wait_o is high for exactly POST_CYCLES cycles and never overlaps busy_o. A request in this window starts nothing and sets error_o.
- R10: A request while busy_o is high is ignored and does not set error_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_we_i | input | 1 | Write strobe for the software address register |
| addr_i | input | 3 | Word index to store |
| data_we_i | input | 1 | Write strobe for the data register |
| data_i | input | 32 | Data word to store |
| wr_req_i | input | 1 | Single-cycle write request |
| err_clr_i | input | 1 | Clears the sticky error flag |
| prot_mask_i | input | 8 | Per-word lock mask; bit w locks word w |
| busy_o | output | 1 | Write in progress |
| post_wait_o | output | 1 | Settling window after a write |
| error_o | output | 1 | Sticky error flag |
| data_o | output | 32 | Data register contents (shifting during a write) |
| fuse_idx_o | output | 8 | Global fuse bit position being addressed |
| fuse_val_o | output | 1 | Value of the bit at fuse_idx_o |
| fuse_pgm_o | output | 1 | Program strobe for the addressed bit |

## Verification
The bench drives writes to word 0, word 7 and two middle words. For each one it measures the BUSY length, which catches a latency that ignores the word index or is off by one slot, and collects strobe positions into a bitmap that must match the data word. A shifter with the wrong direction, no zero fill, or strobes in the positioning slots would break that bitmap. In the third cycle of a write, it rewrites the address and data registers and raises a request. A design that reads the live address register would run for the wrong time, and one that accepts the data would burn a pattern of all ones. Further tests send a request into the settling window, send one to a locked word, and send one while ERROR is set. A design that restarts or loses the sticky flag in these cases would show BUSY or a clear ERROR.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROG   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/otp_prot_check.sv
module otp_prot_check #(
  parameter int WORDS = 8,
  localparam int AW = $clog2(WORDS)
) (
  input  logic [WORDS-1:0] prot_mask_i,
  input  logic [AW-1:0]    word_i,
  output logic             locked_o
);
  always_comb begin
    locked_o = 1'b0;
    for (int w = 0; w < WORDS; w++) begin
      if (word_i == AW'(w)) locked_o = prot_mask_i[w];
    end
  end
endmodule

// File: rtl/otp_slot_timer.sv
module otp_slot_timer #(
  parameter int WORDS        = 8,
  parameter int WORD_BITS    = 32,
  parameter int CLKS_PER_BIT = 32,
  localparam int AW   = $clog2(WORDS),
  localparam int SW   = $clog2(WORDS * WORD_BITS),
  localparam int TW   = $clog2(CLKS_PER_BIT),
  localparam logic [TW-1:0] TMAX = TW'(CLKS_PER_BIT - 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  input  logic [AW-1:0] word_i,
  output logic [SW-1:0] slot_o,
  output logic          data_phase_o,
  output logic          bit_start_o,
  output logic          bit_end_o,
  output logic          last_o
);
  logic [TW-1:0] tick_q;
  logic [SW-1:0] slot_q;
  logic [SW-1:0] first_data, last_slot;

  // chain position of the selected word: lower words are stepped past first
  assign first_data = SW'(word_i) * SW'(WORD_BITS);
  assign last_slot  = first_data + SW'(WORD_BITS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      slot_q <= '0;
    end else if (start_i) begin
      tick_q <= '0;
      slot_q <= '0;
    end else if (run_i) begin
      if (tick_q == TMAX) begin
        tick_q <= '0;
        slot_q <= slot_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign slot_o       = slot_q;
  assign data_phase_o = run_i && (slot_q >= first_data);
  assign bit_start_o  = run_i && (tick_q == '0);
  assign bit_end_o    = run_i && (tick_q == TMAX);
  assign last_o       = bit_end_o && (slot_q == last_slot);

  AST_SLOT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> slot_q <= last_slot); // R2
endmodule

// File: rtl/otp_bit_shifter.sv
module otp_bit_shifter #(
  parameter int WORD_BITS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sw_we_i,
  input  logic [WORD_BITS-1:0] sw_data_i,
  input  logic                 lock_i,
  input  logic                 shift_i,
  output logic [WORD_BITS-1:0] data_o
);
  logic [WORD_BITS-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  data_q <= '0;
    else if (shift_i)             data_q <= {1'b0, data_q[WORD_BITS-1:1]};
    else if (sw_we_i && !lock_i)  data_q <= sw_data_i;
  end

  assign data_o = data_q;

  AST_DATA_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && !shift_i |=> $stable(data_q)); // R6
  AST_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> !data_q[WORD_BITS-1]); // R3
endmodule

// File: rtl/otp_post_timer.sv
module otp_post_timer #(
  parameter int POST_CYCLES = 400,
  localparam int PW = $clog2(POST_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic done_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= PW'(POST_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
  assign done_o   = (cnt_q == PW'(1));

  AST_POST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == PW'(POST_CYCLES)); // R9
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int WORDS        = 8,
  parameter int WORD_BITS    = 32,
  parameter int CLKS_PER_BIT = 32,
  parameter int CLK_MHZ      = 200,
  parameter int POST_US      = 2,
  localparam int AW          = $clog2(WORDS),
  localparam int SW          = $clog2(WORDS * WORD_BITS),
  localparam int POST_CYCLES = CLK_MHZ * POST_US
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 addr_we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic                 data_we_i,
  input  logic [WORD_BITS-1:0] data_i,
  input  logic                 wr_req_i,
  input  logic                 err_clr_i,
  input  logic [WORDS-1:0]     prot_mask_i,
  output logic                 busy_o,
  output logic                 post_wait_o,
  output logic                 error_o,
  output logic [WORD_BITS-1:0] data_o,
  output logic [SW-1:0]        fuse_idx_o,
  output logic                 fuse_val_o,
  output logic                 fuse_pgm_o
);
  seq_state_e state_q;
  logic [AW-1:0] addr_sw_q, addr_lat_q;
  logic          err_q;
  logic          locked, go, run;
  logic [SW-1:0] slot;
  logic          data_phase, bit_start, bit_end, last_bit;
  logic          post_done, post_active;
  logic [WORD_BITS-1:0] data_q;

  otp_prot_check #(.WORDS(WORDS)) u_prot (
    .prot_mask_i (prot_mask_i),
    .word_i      (addr_sw_q),
    .locked_o    (locked)
  );

  assign run = (state_q == ST_PROG);
  assign go  = wr_req_i && (state_q == ST_IDLE) && !err_q && !locked;

  otp_slot_timer #(
    .WORDS(WORDS), .WORD_BITS(WORD_BITS), .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_slots (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (go),
    .run_i        (run),
    .word_i       (addr_lat_q),
    .slot_o       (slot),
    .data_phase_o (data_phase),
    .bit_start_o  (bit_start),
    .bit_end_o    (bit_end),
    .last_o       (last_bit)
  );

  otp_bit_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_we_i   (data_we_i),
    .sw_data_i (data_i),
    .lock_i    (run),
    .shift_i   (data_phase && bit_end),
    .data_o    (data_q)
  );

  otp_post_timer #(.POST_CYCLES(POST_CYCLES)) u_post (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (last_bit),
    .active_o (post_active),
    .done_o   (post_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:   if (go)        state_q <= ST_PROG;
        ST_PROG:   if (last_bit)  state_q <= ST_SETTLE;
        ST_SETTLE: if (post_done) state_q <= ST_IDLE;
        default:                  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_sw_q  <= '0;
      addr_lat_q <= '0;
    end else begin
      if (addr_we_i) addr_sw_q  <= addr_i;
      if (go)        addr_lat_q <= addr_sw_q;
    end
  end

  // error: clear wins; set on locked target or on request in settle window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (err_clr_i) err_q <= 1'b0;
    else if (wr_req_i && !err_q &&
             (((state_q == ST_IDLE) && locked) || (state_q == ST_SETTLE)))
      err_q <= 1'b1;
  end

  assign busy_o      = run;
  assign post_wait_o = (state_q == ST_SETTLE);
  assign error_o     = err_q;
  assign data_o      = data_q;
  assign fuse_idx_o  = run ? slot : '0;
  assign fuse_val_o  = data_phase && data_q[0];
  assign fuse_pgm_o  = data_phase && bit_start && data_q[0];

  AST_PGM_IN_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_pgm_o |-> busy_o); // R4
  AST_PGM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_pgm_o |=> !fuse_pgm_o); // R4
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(addr_lat_q)); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && post_wait_o)); // R9
  AST_SETTLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> post_wait_o && post_active); // R9
  AST_LOCK_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && !busy_o && !post_wait_o && !error_o && locked |=> !busy_o && error_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o && !err_clr_i |=> error_o); // R8
  AST_REQ_IN_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !error_o |=> !error_o); // R10
endmodule

// File: tb/otp_prog_seq_test.sv
module otp_prog_seq_test;
  localparam int CPB  = 32;
  localparam int POST = 400;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        data_we_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        wr_req_i = 1'b0;
  logic        err_clr_i = 1'b0;
  logic [7:0]  prot_mask_i = '0;
  logic        busy_o, post_wait_o, error_o, fuse_val_o, fuse_pgm_o;
  logic [31:0] data_o;
  logic [7:0]  fuse_idx_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  otp_prog_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_we_i(addr_we_i), .addr_i(addr_i),
    .data_we_i(data_we_i), .data_i(data_i), .wr_req_i(wr_req_i),
    .err_clr_i(err_clr_i), .prot_mask_i(prot_mask_i), .busy_o(busy_o),
    .post_wait_o(post_wait_o), .error_o(error_o), .data_o(data_o),
    .fuse_idx_o(fuse_idx_o), .fuse_val_o(fuse_val_o), .fuse_pgm_o(fuse_pgm_o)
  );

  always #2.5 clk_i = ~clk_i;

  // {word index, data}
  localparam logic [34:0] VEC [4] = '{
    {3'd0, 32'h8000_0001},
    {3'd3, 32'hA5A5_0F0F},
    {3'd7, 32'hFFFF_FFFF},
    {3'd5, 32'h0000_0000}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_regs(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_we_i = 1'b1; addr_i = a; data_we_i = 1'b1; data_i = d;
    @(negedge clk_i);
    addr_we_i = 1'b0; data_we_i = 1'b0;
  endtask

  task automatic pulse_req();
    wr_req_i = 1'b1;
    @(negedge clk_i);
    wr_req_i = 1'b0;
  endtask

  task automatic run_write(input logic [2:0] n, input logic [31:0] d,
                           input bit inject, input bit settle_req);
    int c = 0;
    int p = 0;
    int strobes = 0;
    int bad = 0;
    int base = int'(n) * 32 * CPB;
    logic [31:0] mask = '0;
    load_regs(n, d);
    pulse_req();
    while (busy_o && c < 20000) begin
      c++;
      if (c == base + 1)   check(data_o == d, "R3 data before shift", data_o, d);
      if (c == base + CPB + 1) check(data_o == (d >> 1), "R3 first shift", data_o, d >> 1);
      if (inject && c == 3) begin
        addr_we_i = 1'b1; addr_i = n ^ 3'd5;
        data_we_i = 1'b1; data_i = 32'hFFFF_FFFF;
        wr_req_i = 1'b1;
      end
      if (inject && c == 4) begin
        addr_we_i = 1'b0; data_we_i = 1'b0; wr_req_i = 1'b0;
      end
      if (fuse_pgm_o) begin
        strobes++;
        if (int'(fuse_idx_o) >= int'(n) * 32 && int'(fuse_idx_o) < int'(n) * 32 + 32)
          mask[int'(fuse_idx_o) - int'(n) * 32] = 1'b1;
        else bad++;
      end
      @(negedge clk_i);
    end
    check(c == (int'(n) + 1) * 32 * CPB, "R2 busy length", c, (int'(n) + 1) * 32 * CPB);
    check(bad == 0, "R3 strobe index range", bad, 0);
    check(mask == d, "R4 strobe bitmap", mask, d);
    check(strobes == $countones(d), "R4 strobe count", strobes, $countones(d));
    check(data_o == 32'h0, "R3 data zero after write", data_o, 0);
    if (inject) check(error_o == 1'b0, "R10 no error from request in write", error_o, 0);
    if (inject) check(mask == d, "R5 R6 target unchanged by writes during busy", mask, d);
    while (post_wait_o && p < 20000) begin
      p++;
      if (settle_req && p == 10) wr_req_i = 1'b1;
      if (settle_req && p == 11) wr_req_i = 1'b0;
      check(!busy_o, "R9 no overlap", busy_o, 0);
      @(negedge clk_i);
    end
    check(p == POST, "R9 settle length", p, POST);
    if (settle_req) begin
      check(error_o == 1'b1, "R9 settle request flags error", error_o, 1);
      repeat (3) @(negedge clk_i);
      check(busy_o == 1'b0, "R9 settle request starts nothing", busy_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!busy_o && !post_wait_o && !error_o && !fuse_pgm_o && data_o == 0,
          "R1 reset state", {busy_o, post_wait_o, error_o, fuse_pgm_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 4; i++)
      run_write(VEC[i][34:32], VEC[i][31:0], i < 2, 1'b0);

    // R7: locked word
    prot_mask_i = 8'h04;
    load_regs(3'd2, 32'hFFFF_0000);
    pulse_req();
    begin
      int seen = 0;
      repeat (40) begin
        if (busy_o || fuse_pgm_o) seen++;
        @(negedge clk_i);
      end
      check(seen == 0, "R7 locked word not programmed", seen, 0);
    end
    check(error_o == 1'b1, "R7 locked word sets error", error_o, 1);

    // R8: requests ignored while error set
    load_regs(3'd1, 32'h1);
    pulse_req();
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0, "R8 request ignored under error", busy_o, 0);
    check(error_o == 1'b1, "R8 error sticky", error_o, 1);
    err_clr_i = 1'b1;
    @(negedge clk_i);
    err_clr_i = 1'b0;
    check(error_o == 1'b0, "R8 error cleared", error_o, 0);
    prot_mask_i = 8'h00;

    // R9: request in settle window
    run_write(3'd0, 32'h0000_0003, 1'b0, 1'b1);
    err_clr_i = 1'b1;
    @(negedge clk_i);
    err_clr_i = 1'b0;

    // R1: reset during a write
    load_regs(3'd4, 32'hFFFF_FFFF);
    pulse_req();
    repeat (50) @(negedge clk_i);
    check(busy_o == 1'b1, "R2 write running before reset", busy_o, 1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(!busy_o && !post_wait_o && !fuse_pgm_o && data_o == 0,
          "R1 reset during write", {busy_o, post_wait_o, fuse_pgm_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule